// File: doc/BRIEF.md
# Deep Color Pixel Unpacker

This block sits behind the TMDS character decoders of a video receiver. Each link clock it may take one decoded 8-bit character on each colour lane. In deep colour modes one pixel's component is spread over more than one character, so the block collects the characters of a pixel group and rebuilds whole 10-bit or 12-bit components. A pixel-valid strobe marks the link cycles that carry a finished pixel. When the strobe is high on fewer than all cycles, the pixel rate is lower than the link rate, as the packing ratio requires.

A data-enable input marks active video. Characters with data-enable low are dropped. The packing phase restarts on the first character of each active period, so a burst that ends part way through a group does not skew the next one. The only control is a 2-bit mode input. Mode must be held steady while data-enable is high.

Top module: `dc_unpack_top`

## Requirements
- R1: While rst_ni is low, pix_valid_o is 0 and every bit of pix_o is 0.
- R2: Mode 0 (24 bpp): every character accepted with de_i high yields a pixel one cycle later. Each component is the character placed in bits [11:4], with bits [3:0] zero.
- R3: Mode 1 (30 bpp): the characters of a group, c0 first, are joined least-significant first into a 40-bit word {c4,c3,c2,c1,c0}. Pixel k of the group (k = 0..3) is word bits [10k+9:10k]. It is output in component bits [11:2], with bits [1:0] zero. Four pixels come out for every five characters.
- R4: Mode 2 (36 bpp): a group of three characters forms the word {c2,c1,c0}. Pixel k (k = 0..1) is word bits [12k+11:12k]. Two pixels come out for every three characters.
- R5: pix_valid_o is high in exactly the cycle after the character that completes a pixel, and low in every other cycle. When it is low, pix_o holds its previous value.
- R6: The first character with de_i high after a cycle with de_i low is character c0 of a new group, whatever was left of an earlier group.
- R7: A character presented with de_i low has no effect. pix_valid_o is low in the next cycle and pix_o holds its value.
- R8: Mode 3 behaves exactly as mode 0.
- R9: Each lane i is unpacked from data_i[8i+7:8i] into pix_o[12i+11:12i]. All lanes share the same phase and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_i | input | 1 | Active video / character valid |
| mode_i | input | 2 | 0: 24 bpp, 1: 30 bpp, 2: 36 bpp, 3: 24 bpp |
| data_i | input | 8*LANES | Decoded characters, lane i in bits [8i+7:8i] |
| pix_valid_o | output | 1 | Pixel present on pix_o |
| pix_o | output | 12*LANES | MSB-aligned components, lane i in bits [12i+11:12i] |

## Verification
The bench builds the block with its default of three lanes. It feeds independent random characters into every lane, so a crossed lane or a wrong bit slice shows up at once. Bursts in 30 bpp and 36 bpp mode are sized to end part way through a group, which tests the phase restart at the start of the next burst. Idle gaps test that dropped characters leave the outputs unchanged. Mode 3 is run with the same stimulus style as mode 0.

// File: rtl/dc_unpack_pkg.sv
package dc_unpack_pkg;
  localparam int unsigned CHAR_W    = 8;
  localparam int unsigned COMP_W    = 12;
  localparam int unsigned MAX_GRP   = 5;
  localparam int unsigned PH_W      = $clog2(MAX_GRP);
  localparam int unsigned HIST_W    = CHAR_W * (MAX_GRP - 1);
  localparam int unsigned GRP_W     = CHAR_W * MAX_GRP;

  typedef enum logic [1:0] {
    MODE_24  = 2'd0,
    MODE_30  = 2'd1,
    MODE_36  = 2'd2,
    MODE_24B = 2'd3
  } dc_mode_e;
endpackage

// File: rtl/dc_phase_ctrl.sv
module dc_phase_ctrl
  import dc_unpack_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      de_i,
  input  dc_mode_e                  mode_i,
  output logic [PH_W-1:0]           phase_o,
  output logic [1:0]                idx_o,
  output logic                      emit_o
);
  logic              de_q;
  logic [PH_W-1:0]   ph_q;
  logic [PH_W-1:0]   last_ph;
  logic              deep;

  always_comb begin
    unique case (mode_i)
      MODE_30: last_ph = PH_W'(4);
      MODE_36: last_ph = PH_W'(2);
      default: last_ph = '0;
    endcase
    deep    = (mode_i == MODE_30) || (mode_i == MODE_36);
    phase_o = (de_i && !de_q) ? '0 : ph_q;
    // deep modes: phase 0 only primes, phase p completes pixel p-1
    emit_o  = de_i && (!deep || (phase_o != '0));
    idx_o   = 2'(phase_o - PH_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q <= 1'b0;
      ph_q <= '0;
    end else begin
      de_q <= de_i;
      if (de_i) ph_q <= (phase_o == last_ph) ? '0 : phase_o + PH_W'(1);
    end
  end
endmodule

// File: rtl/dc_lane_unpack.sv
module dc_lane_unpack
  import dc_unpack_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 de_i,
  input  dc_mode_e             mode_i,
  input  logic [PH_W-1:0]      phase_i,
  input  logic [1:0]           idx_i,
  input  logic [CHAR_W-1:0]    char_i,
  output logic [COMP_W-1:0]    comp_o
);
  logic [HIST_W-1:0] hist_q;
  logic [GRP_W-1:0]  word;

  always_comb begin
    word = {{CHAR_W{1'b0}}, hist_q};
    word[CHAR_W*phase_i +: CHAR_W] = char_i;
    unique case (mode_i)
      MODE_30: comp_o = {word[10*idx_i +: 10], 2'b00};
      MODE_36: comp_o = word[12*idx_i +: 12];
      default: comp_o = {char_i, {(COMP_W-CHAR_W){1'b0}}};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (de_i && (phase_i < PH_W'(MAX_GRP - 1)))
      hist_q[CHAR_W*phase_i +: CHAR_W] <= char_i;
  end
endmodule

// File: rtl/dc_unpack_top.sv
module dc_unpack_top
  import dc_unpack_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      de_i,
  input  logic [1:0]                mode_i,
  input  logic [CHAR_W*LANES-1:0]   data_i,
  output logic                      pix_valid_o,
  output logic [COMP_W*LANES-1:0]   pix_o
);
  dc_mode_e          mode;
  logic [PH_W-1:0]   phase;
  logic [1:0]        idx;
  logic              emit;

  assign mode = dc_mode_e'(mode_i);

  dc_phase_ctrl u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .de_i    (de_i),
    .mode_i  (mode),
    .phase_o (phase),
    .idx_o   (idx),
    .emit_o  (emit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [COMP_W-1:0] comp;

    dc_lane_unpack u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .de_i    (de_i),
      .mode_i  (mode),
      .phase_i (phase),
      .idx_i   (idx),
      .char_i  (data_i[CHAR_W*l +: CHAR_W]),
      .comp_o  (comp)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   pix_o[COMP_W*l +: COMP_W] <= '0;
      else if (emit) pix_o[COMP_W*l +: COMP_W] <= comp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_valid_o <= 1'b0;
    else         pix_valid_o <= emit;
  end
endmodule

// File: rtl/dc_unpack_checker.sv
module dc_unpack_checker
  import dc_unpack_pkg::*;
#(
  parameter int unsigned LANES = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      de_i,
  input  logic [1:0]                mode_i,
  input  logic                      pix_valid_o,
  input  logic [COMP_W*LANES-1:0]   pix_o
);
  logic       de_q;
  logic [1:0] mode_q;
  logic       any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_q   <= 1'b0;
      mode_q <= 2'd0;
      any_q  <= 1'b0;
    end else begin
      de_q   <= de_i;
      mode_q <= mode_i;
      any_q  <= 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni -> (!pix_valid_o && pix_o == '0)));

  assert_narrow_every_char_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> pix_valid_o);

  assert_hold_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_q && !pix_valid_o) |-> $stable(pix_o));

  assert_group_start_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_i && !de_q && (mode_i == 2'd1 || mode_i == 2'd2)) |=> !pix_valid_o);

  assert_dropped_char_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_i |=> !pix_valid_o);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    assert_lsb_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pix_valid_o && mode_q == 2'd1) |-> (pix_o[COMP_W*l +: 2] == 2'b00));
  end
endmodule

bind dc_unpack_top dc_unpack_checker #(.LANES(LANES)) u_dc_unpack_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .de_i        (de_i),
  .mode_i      (mode_i),
  .pix_valid_o (pix_valid_o),
  .pix_o       (pix_o)
);

// File: tb/dc_unpack_top_bench.sv
`timescale 1ns/1ps
module dc_unpack_top_bench;
  localparam int LANES = 3;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  de_i = 1'b0;
  logic [1:0]            mode_i = 2'd0;
  logic [8*LANES-1:0]    data_i = '0;
  logic                  pix_valid_o;
  logic [12*LANES-1:0]   pix_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  longint      acc [LANES];
  int          cnt [LANES];
  logic [11:0] exp_pix [LANES];
  logic        exp_valid = 1'b0;
  logic        m_de_q = 1'b0;
  string       tag = "R1";

  always #4 clk_i = ~clk_i;

  dc_unpack_top #(.LANES(LANES)) u_dc_unpack_top (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .de_i        (de_i),
    .mode_i      (mode_i),
    .data_i      (data_i),
    .pix_valid_o (pix_valid_o),
    .pix_o       (pix_o)
  );

  task automatic check_out();
    checks++;
    if (pix_valid_o !== exp_valid) begin
      errors++;
      $display("FAIL R5 (%s) valid actual %0b expected %0b at %0t", tag, pix_valid_o, exp_valid, $time);
    end
    for (int l = 0; l < LANES; l++) begin
      checks++;
      if (pix_o[12*l +: 12] !== exp_pix[l]) begin
        errors++;
        $display("FAIL %s/R9 lane %0d pix actual %03h expected %03h at %0t",
                 tag, l, pix_o[12*l +: 12], exp_pix[l], $time);
      end
    end
  endtask

  task automatic cyc(input logic de, input logic [1:0] mode);
    int  w;
    bit  start;
    bit  emit;
    @(negedge clk_i);
    check_out();
    de_i   = de;
    mode_i = mode;
    for (int l = 0; l < LANES; l++) data_i[8*l +: 8] = 8'($urandom);
    start = de && !m_de_q;
    m_de_q = de;
    w = (mode == 2'd1) ? 10 : (mode == 2'd2) ? 12 : 8;
    if (!de)                           tag = "R7";
    else if (start && w != 8)          tag = "R6";
    else if (mode == 2'd0)             tag = "R2";
    else if (mode == 2'd3)             tag = "R8";
    else if (mode == 2'd1)             tag = "R3";
    else                               tag = "R4";
    emit = 1'b0;
    if (de) begin
      for (int l = 0; l < LANES; l++) begin
        if (start) begin acc[l] = 0; cnt[l] = 0; end
        acc[l] = acc[l] | (longint'(data_i[8*l +: 8]) << cnt[l]);
        cnt[l] += 8;
        if (cnt[l] >= w) begin
          emit = 1'b1;
          exp_pix[l] = 12'((acc[l] & ((longint'(1) << w) - 1)) << (12 - w));
          acc[l] = acc[l] >> w;
          cnt[l] -= w;
        end
      end
    end
    exp_valid = emit;
  endtask

  task automatic burst(input logic [1:0] mode, input int n, input int gap);
    for (int i = 0; i < n; i++)   cyc(1'b1, mode);
    for (int i = 0; i < gap; i++) cyc(1'b0, mode);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin acc[l] = 0; cnt[l] = 0; exp_pix[l] = '0; end
    repeat (3) @(negedge clk_i);
    tag = "R1";
    check_out();
    rst_ni = 1'b1;
    burst(2'd0, 12, 3);
    burst(2'd1, 20, 2);
    burst(2'd1, 13, 3);   // ends mid-group
    burst(2'd1, 7, 1);
    burst(2'd1, 25, 2);
    burst(2'd2, 9, 2);
    burst(2'd2, 8, 4);    // ends mid-group
    burst(2'd2, 1, 1);
    burst(2'd2, 16, 2);
    burst(2'd3, 10, 2);
    burst(2'd1, 4, 0);
    burst(2'd1, 40, 3);
    for (int r = 0; r < 30; r++) burst(2'($urandom_range(0, 3)), $urandom_range(1, 17), $urandom_range(1, 3));
    cyc(1'b0, 2'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule